// File: doc/BRIEF.md
# Round-Robin Event Distributor

This block accepts a single transition-signaled input, where every change of level (rising or falling) stands for one event. It hands successive events to K outputs in a fixed rotating order: the first event after reset goes to output 1, the next to output 2, and so on up to output K, after which the rotation wraps back to output 1. Each output is itself a transition-signaled line, so it inverts its level once for every event it receives.

The default K is 5, and for that size the block is built from smaller parts. An XOR merge combines the external event with an internal feedback event and drives a three-way rotating distributor. Each distributor way drives a two-way toggle, and a toggle sends odd-numbered hits to its first output and even-numbered hits to its second.

The first toggle serves outputs 1 and 4, and the second serves outputs 2 and 5. The third serves output 3 on its first output, while its second output is the feedback event. That feedback event is resolved within the same clock cycle as the external event that caused it, so it never counts as a new event. For any other K a plain rotating pointer is used instead. A synchronous detector turns input level changes into single-cycle events.

Top module: `rr_event_spreader`

## Requirements
- R1: While reset is held, every output reads 0. The first input event after reset inverts output 1 (bit 0 of `y_out`).
- R2: A change of `ev_in` in either direction is one event. A level that is held produces no event.
- R3: Each event inverts exactly one output, and that change is visible after the first rising clock edge at which the new input level is sampled.
- R4: No output changes in a cycle that has no input event.
- R5: Events go to outputs in the order bit 0, bit 1, …, bit K-1, then wrap to bit 0.
- R6: With K = 5, the sixth event after reset (which passes through the internal feedback path) inverts bit 0 and nothing else, and no second-stage hit ever reaches the last distributor way.
- R7: Outputs are transition-signaled: a second event delivered to the same output returns it to its earlier level.
- R8: Input events on consecutive clock cycles are each delivered, with none lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | 1 | Transition-signaled event input |
| y_out | output | K | Transition-signaled outputs; bit i is output i+1 |

## Verification
Every result is due one rising edge after the input level changes, because the detector and the output registers see the new level at that same edge. The bench changes `ev_in` on a falling edge and compares `y_out` with its model on the next falling edge, which is exactly one rising edge later. This keeps each comparison aligned with the event that caused it. The bound checker relates each cycle's output change to the input change sampled one edge earlier, using its own delayed copies of both.

// File: rtl/rr_spread_pkg.sv
package rr_spread_pkg;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } tog_phase_e;

    localparam int unsigned COMPOSED_K = 5;
    localparam int unsigned MID_WAYS   = 3;

    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/rr_level_to_event.sv
module rr_level_to_event (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic ev
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign ev = lvl ^ lvl_q;
endmodule

// File: rtl/rr_ring.sv
module rr_ring #(
    parameter int unsigned WAYS = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hit,
    input  logic            hit_extra,
    output logic [WAYS-1:0] fire_a,
    output logic [WAYS-1:0] fire_b
);
    import rr_spread_pkg::*;

    localparam int unsigned PW = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [PW-1:0] ptr;
    logic [PW-1:0] step1;
    logic [PW-1:0] step2;

    always_comb begin
        step1 = PW'(wrap_inc(32'(ptr), WAYS));
        step2 = PW'(wrap_inc(32'(step1), WAYS));
    end

    assign fire_a = hit       ? (WAYS'(1) << ptr)   : '0;
    assign fire_b = hit_extra ? (WAYS'(1) << step1) : '0;

    always_ff @(posedge clk) begin
        if (rst)            ptr <= '0;
        else if (hit_extra) ptr <= step2;
        else if (hit)       ptr <= step1;
    end
endmodule

// File: rtl/rr_toggle2.sv
module rr_toggle2 (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    output logic out_first,
    output logic out_second
);
    import rr_spread_pkg::*;

    tog_phase_e phase;

    assign out_first  = hit && (phase == PH_FIRST);
    assign out_second = hit && (phase == PH_SECOND);

    always_ff @(posedge clk) begin
        if (rst)      phase <= PH_FIRST;
        else if (hit) phase <= (phase == PH_FIRST) ? PH_SECOND : PH_FIRST;
    end
endmodule

// File: rtl/rr_event_spreader.sv
module rr_event_spreader #(
    parameter int unsigned K = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ev_in,
    output logic [K-1:0] y_out
);
    import rr_spread_pkg::*;

    logic         ev;
    logic [K-1:0] fire;
    logic [2:0]   late_spill;

    rr_level_to_event u_det (
        .clk (clk),
        .rst (rst),
        .lvl (ev_in),
        .ev  (ev)
    );

    generate
        if (K == COMPOSED_K) begin : g_composed
            logic [MID_WAYS-1:0] f_a;
            logic [MID_WAYS-1:0] f_b;
            logic [MID_WAYS-1:0] t_hit;
            logic [MID_WAYS-1:0] t_first;
            logic [MID_WAYS-1:0] t_second;
            logic                feedback;

            rr_ring #(.WAYS(MID_WAYS)) u_mid (
                .clk       (clk),
                .rst       (rst),
                .hit       (ev),
                .hit_extra (feedback),
                .fire_a    (f_a),
                .fire_b    (f_b)
            );

            for (genvar i = 0; i < MID_WAYS; i++) begin : g_tog
                if (i == MID_WAYS - 1) begin : g_last
                    assign t_hit[i] = f_a[i];
                end else begin : g_mid
                    assign t_hit[i] = f_a[i] | f_b[i];
                end
                rr_toggle2 u_tog (
                    .clk        (clk),
                    .rst        (rst),
                    .hit        (t_hit[i]),
                    .out_first  (t_first[i]),
                    .out_second (t_second[i])
                );
            end

            assign feedback   = t_second[2];
            assign late_spill = {f_b[2], 2'b00};
            assign fire       = {t_second[1], t_second[0], t_first[2], t_first[1], t_first[0]};
        end else begin : g_flat
            logic [K-1:0] f_a;
            logic [K-1:0] f_b;

            rr_ring #(.WAYS(K)) u_flat (
                .clk       (clk),
                .rst       (rst),
                .hit       (ev),
                .hit_extra (1'b0),
                .fire_a    (f_a),
                .fire_b    (f_b)
            );

            assign fire       = f_a | f_b;
            assign late_spill = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) y_out <= '0;
        else     y_out <= y_out ^ fire;
    end
endmodule

// File: rtl/rr_event_spreader_chk.sv
module rr_event_spreader_chk #(
    parameter int unsigned K = 5
) (
    input logic         clk,
    input logic         rst,
    input logic         ev_in,
    input logic [K-1:0] y_out,
    input logic [2:0]   late_spill
);
    localparam int unsigned IW = (K > 1) ? $clog2(K) : 1;

    logic [K-1:0]  y_q;
    logic          d_q;
    logic          d_qq;
    logic [IW-1:0] want;

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q  <= '0;
            d_q  <= 1'b0;
            d_qq <= 1'b0;
            want <= '0;
        end else begin
            y_q  <= y_out;
            d_q  <= ev_in;
            d_qq <= d_q;
            if (y_out != y_q)
                want <= (32'(want) == K - 1) ? '0 : want + 1'b1;
        end
    end

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (y_out == '0));

    assert_single_flip_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(y_out ^ y_q));

    assert_flip_iff_event_R4: assert property (@(posedge clk) disable iff (rst)
        ((y_out != y_q) == (d_q != d_qq)));

    assert_rotation_R5: assert property (@(posedge clk) disable iff (rst)
        (y_out != y_q) |-> ((y_out ^ y_q) == (K'(1) << want)));

    assert_feedback_folded_R6: assert property (@(posedge clk) disable iff (rst)
        (late_spill == 3'b000));
endmodule

bind rr_event_spreader rr_event_spreader_chk #(.K(K)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ev_in      (ev_in),
    .y_out      (y_out),
    .late_spill (late_spill)
);

// File: tb/test_rr_event_spreader.sv
module test_rr_event_spreader;
    localparam int unsigned K = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ev_in = 1'b0;
    logic [K-1:0] y_out;

    int unsigned  n_chk  = 0;
    int unsigned  n_bad  = 0;
    logic [K-1:0] exp_y  = '0;
    int unsigned  nxt    = 0;
    bit           ended  = 1'b0;

    always #10 clk = ~clk;

    rr_event_spreader #(.K(K)) i_rr_event_spreader (
        .clk   (clk),
        .rst   (rst),
        .ev_in (ev_in),
        .y_out (y_out)
    );

    function automatic logic [K-1:0] deliver(input logic [K-1:0] cur, input int unsigned idx);
        return cur ^ (K'(1) << idx);
    endfunction

    task automatic check(input string req, input logic [K-1:0] act, input logic [K-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: y_out=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cycle(input bit flip, input string req);
        if (flip) begin
            ev_in = ~ev_in;
            exp_y = deliver(exp_y, nxt);
            nxt   = (nxt + 1) % K;
        end
        @(negedge clk);
        check(req, y_out, exp_y);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: y_out=%b expected=%b", y_out, exp_y);
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset", y_out, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", y_out, '0);

        // R1: first event goes to bit 0
        cycle(1'b1, "R1 first event");
        // R4: held level, no change
        repeat (3) cycle(1'b0, "R4 idle");
        // R8 / R5 / R6 / R7: back-to-back events through two full rotations
        for (int i = 0; i < 11; i++) cycle(1'b1, "R8 R5 R6 R7 back-to-back");
        cycle(1'b0, "R4 idle");
        // R2: both polarities in random stream
        for (int i = 0; i < 400; i++) cycle(($urandom % 3) == 0, "R2 R3 R5 random");

        // R1: reset mid-run returns outputs to 0 and restarts rotation
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 re-reset", y_out, '0);
        ev_in = 1'b0;
        exp_y = '0;
        nxt   = 0;
        rst   = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 6; i++) cycle(1'b1, "R6 sixth event folds back");
        check("R6 pattern", y_out, 5'b11110);
        finish_run();
    end
endmodule